// File: doc/BRIEF.md
# Polled Keyboard and Display Port

This block sits on a 16-bit processor memory bus and turns four fixed high addresses into a character console. Two of the addresses are status words and two are data words. One pair serves a keyboard, which supplies 8-bit characters with a one-cycle strobe. The other pair serves a display, which receives 8-bit characters with a one-cycle valid pulse and returns an acknowledge once it has taken the character.

Software runs the console by polling. A read-character routine spins on the keyboard status word until its ready bit is set, then reads the keyboard data word, which clears that ready bit. A write-character routine spins on the display status word until its ready bit is set, then writes the display data word. That write sends the character out and clears ready until the display acknowledges. String output and halt routines are built from these two loops. Any bus access to an address outside the four is forwarded unchanged to main memory.

The keyboard side is a two-state machine: `KB_EMPTY` and `KB_HELD`. Its transitions are *key_arrive* (EMPTY to HELD on a strobe), *key_overwrite* (HELD to HELD on a strobe), *key_consume* (HELD to EMPTY on a data read with no strobe) and *key_idle* (stay). The display side is a three-state machine: `DP_READY`, `DP_SEND` and `DP_WAIT`. Its transitions are *char_accept* (READY to SEND on a data write), *ack_early* (SEND to READY on an acknowledge), *send_done* (SEND to WAIT with no acknowledge), *ack_late* (WAIT to READY on an acknowledge) and *hold* (stay in the same state).

Top module: `kbd_disp_mmio`

## Requirements
- R1: Only the addresses 0xFE00 (keyboard status), 0xFE02 (keyboard data), 0xFE04 (display status) and 0xFE06 (display data) belong to the device. For every other address, `mem_rd`/`mem_wr` follow `bus_rd`/`bus_wr` in the same cycle and `bus_rdata` equals `mem_rdata`.
- R2: A status read returns the ready flag in bit 15 and zeros in bits 14..0. Keyboard ready comes from 0xFE00 and display ready from 0xFE04.
- R3: A `key_stb` cycle latches `key_char` and sets keyboard ready from the next cycle. A read of 0xFE02 returns `{8'h00, held character}`.
- R4: A read of 0xFE02 clears keyboard ready from the next cycle. If a strobe arrives in the same cycle, the strobe wins and ready stays set.
- R5: A strobe while keyboard ready is set replaces the held character.
- R6: A write to 0xFE06 while display ready is set drives `disp_vld` high for exactly the next cycle, with `disp_char` = `bus_wdata[7:0]`, and clears display ready.
- R7: Display ready returns in the cycle after `disp_ack` is sampled while ready is clear, including during the valid cycle. An acknowledge while ready is set has no effect.
- R8: A write to 0xFE06 while display ready is clear is dropped: no pulse, and `disp_char` is unchanged.
- R9: After reset, keyboard ready is 0, display ready is 1, `disp_vld` is 0 and `disp_char` is 0.
- R10: Writes to 0xFE00, 0xFE02 and 0xFE04 have no effect. No access to a device address reaches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Bus read request |
| bus_wr | input | 1 | Bus write request |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data (device word or memory word) |
| mem_rd | output | 1 | Read forwarded to main memory |
| mem_wr | output | 1 | Write forwarded to main memory |
| mem_rdata | input | 16 | Read data from main memory |
| key_stb | input | 1 | Keyboard character strobe |
| key_char | input | 8 | Keyboard character |
| disp_vld | output | 1 | Display character valid pulse |
| disp_char | output | 8 | Display character |
| disp_ack | input | 1 | Display has taken the character |

## Verification
The bench goes after the boundaries around each address. Odd neighbours such as 0xFE01 and 0xFE08 must reach memory: a decoder that masks low bits would capture them and return device words. It drives a strobe and a data read in the same cycle; a design where the read wins would lose a fresh character. It sends an acknowledge during the valid cycle itself and while ready is already set: the first, if missed, would hang the display loop, and the second, if honoured, would allow a second send before the display had taken the first. A long random phase mixes writes to the busy display with status writes, so a design that sent dropped characters or let status writes change state would differ from the reference model.

// File: rtl/kdm_pkg.sv
package kdm_pkg;
    parameter int AW = 16;
    parameter int DW = 16;
    parameter int CW = 8;
    parameter int NREG = 4;

    typedef enum logic [1:0] {
        SEL_KSTAT = 2'd0,
        SEL_KDATA = 2'd1,
        SEL_DSTAT = 2'd2,
        SEL_DDATA = 2'd3
    } reg_sel_e;

    typedef enum logic { KB_EMPTY, KB_HELD } kb_state_e;
    typedef enum logic [1:0] { DP_READY, DP_SEND, DP_WAIT } dp_state_e;

    function automatic logic [AW-1:0] reg_addr(input int idx);
        return 16'hFE00 + AW'(2 * idx);
    endfunction
endpackage

// File: rtl/kdm_decode.sv
module kdm_decode
    import kdm_pkg::*;
(
    input  logic [AW-1:0] addr,
    output logic          hit,
    output reg_sel_e      sel
);
    localparam int SW = $clog2(NREG);
    logic [NREG-1:0] match;

    for (genvar g = 0; g < NREG; g++) begin : g_match
        assign match[g] = (addr == reg_addr(g));
    end

    always_comb begin
        sel = SEL_KSTAT;
        for (int i = 0; i < NREG; i++) begin
            if (match[i]) sel = reg_sel_e'(i[SW-1:0]);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/kdm_kbd_fsm.sv
module kdm_kbd_fsm
    import kdm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_stb,
    input  logic [CW-1:0] key_char,
    input  logic          rd_data,
    output logic          ready,
    output logic [CW-1:0] held
);
    kb_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            KB_EMPTY: if (key_stb) state_nx = KB_HELD;
            KB_HELD:  if (!key_stb && rd_data) state_nx = KB_EMPTY;
            default:  state_nx = KB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KB_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       held <= '0;
        else if (key_stb) held <= key_char;
    end

    assign ready = (state == KB_HELD);

    assert_strobe_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_stb |=> ready && held == $past(key_char));
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !key_stb) |=> !ready);
endmodule

// File: rtl/kdm_disp_fsm.sv
module kdm_disp_fsm
    import kdm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic [CW-1:0] wdata,
    input  logic          ack,
    output logic          ready,
    output logic          vld,
    output logic [CW-1:0] char_q
);
    dp_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            DP_READY: if (wr_data) state_nx = DP_SEND;
            DP_SEND:  state_nx = ack ? DP_READY : DP_WAIT;
            DP_WAIT:  if (ack) state_nx = DP_READY;
            default:  state_nx = DP_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DP_READY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            char_q <= '0;
        else if (state == DP_READY && wr_data) char_q <= wdata;
    end

    assign ready = (state == DP_READY);
    assign vld   = (state == DP_SEND);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);
    assert_accept_pulses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_data) |=> vld && !ready);
    assert_busy_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_data) |=> $stable(char_q) && !vld);
    assert_idle_ack_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !wr_data) |=> ready);
endmodule

// File: rtl/kbd_disp_mmio.sv
module kbd_disp_mmio
    import kdm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic [15:0]   mem_rdata,
    input  logic          key_stb,
    input  logic [7:0]    key_char,
    output logic          disp_vld,
    output logic [7:0]    disp_char,
    input  logic          disp_ack
);
    localparam int PAD = DW - CW;

    logic     hit;
    reg_sel_e sel;
    logic     kb_ready, dp_ready;
    logic [CW-1:0] kb_held;
    logic     rd_kdata, wr_ddata;

    kdm_decode u_dec (.addr(bus_addr), .hit(hit), .sel(sel));

    assign rd_kdata = bus_rd && hit && (sel == SEL_KDATA);
    assign wr_ddata = bus_wr && hit && (sel == SEL_DDATA);

    kdm_kbd_fsm u_kbd (
        .clk(clk), .rst_n(rst_n), .key_stb(key_stb), .key_char(key_char),
        .rd_data(rd_kdata), .ready(kb_ready), .held(kb_held)
    );

    kdm_disp_fsm u_dsp (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_ddata), .wdata(bus_wdata[CW-1:0]),
        .ack(disp_ack), .ready(dp_ready), .vld(disp_vld), .char_q(disp_char)
    );

    assign mem_rd = bus_rd && !hit;
    assign mem_wr = bus_wr && !hit;

    always_comb begin
        bus_rdata = mem_rdata;
        if (hit) begin
            unique case (sel)
                SEL_KSTAT: bus_rdata = {kb_ready, {(DW-1){1'b0}}};
                SEL_KDATA: bus_rdata = {{PAD{1'b0}}, kb_held};
                SEL_DSTAT: bus_rdata = {dp_ready, {(DW-1){1'b0}}};
                SEL_DDATA: bus_rdata = '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_status_format_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (sel == SEL_KSTAT || sel == SEL_DSTAT)) |-> bus_rdata[14:0] == '0);
endmodule

// File: tb/tb_kbd_disp_mmio.sv
module tb_kbd_disp_mmio;
    logic clk = 0, rst_n = 0;
    logic [15:0] bus_addr = 0, bus_wdata = 0, mem_rdata = 0;
    logic bus_rd = 0, bus_wr = 0, key_stb = 0, disp_ack = 0;
    logic [7:0] key_char = 0;
    wire [15:0] bus_rdata;
    wire mem_rd, mem_wr, disp_vld;
    wire [7:0] disp_char;

    int checks = 0, errors = 0;
    int cyc = 0;

    // reference model state
    bit m_kr, m_dr, m_vld;
    bit [7:0] m_kc, m_dc;

    kbd_disp_mmio dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_kr = 0; m_kc = 0; m_dr = 1; m_vld = 0; m_dc = 0;
        end else begin
            cyc++;
            if (key_stb) begin m_kr = 1; m_kc = key_char; end
            else if (bus_rd && bus_addr == 16'hFE02) m_kr = 0;
            if (bus_wr && bus_addr == 16'hFE06 && m_dr) begin
                m_dc = bus_wdata[7:0]; m_dr = 0; m_vld = 1;
            end else begin
                m_vld = 0;
                if (!m_dr && disp_ack) m_dr = 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    function automatic bit is_dev(input logic [15:0] a);
        return a == 16'hFE00 || a == 16'hFE02 || a == 16'hFE04 || a == 16'hFE06;
    endfunction

    // compare all outputs against the model, at the falling edge
    task automatic compare_all();
        logic [15:0] exp;
        if (!is_dev(bus_addr)) exp = mem_rdata;
        else case (bus_addr)
            16'hFE00: exp = {m_kr, 15'b0};
            16'hFE02: exp = {8'h00, m_kc};
            16'hFE04: exp = {m_dr, 15'b0};
            default:  exp = 16'h0000;
        endcase
        chk("R1/R2/R3 rdata", bus_rdata, exp);
        chk("R1/R10 mem_rd", mem_rd, bus_rd && !is_dev(bus_addr));
        chk("R1/R10 mem_wr", mem_wr, bus_wr && !is_dev(bus_addr));
        chk("R6/R8 disp_vld", disp_vld, m_vld);
        chk("R6/R8 disp_char", disp_char, m_dc);
    endtask

    task automatic step(input logic [15:0] a, input bit rd, input bit wr, input logic [15:0] wd,
                        input bit ks, input logic [7:0] kc, input bit ak);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        key_stb = ks; key_char = kc; disp_ack = ak;
        mem_rdata = 16'hA5A5 ^ 16'(cyc);
        #1;
        compare_all();
        @(negedge clk);
    endtask

    initial begin
        #20000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] addrs [8] = '{16'hFE00, 16'hFE02, 16'hFE04, 16'hFE06,
                                   16'hFE01, 16'hFE08, 16'h1234, 16'h0000};
        repeat (2) @(negedge clk);
        // R9: reset state
        bus_addr = 16'hFE00; bus_rd = 1; #1;
        chk("R9 kbd ready", bus_rdata, 16'h0000);
        bus_addr = 16'hFE04; #1;
        chk("R9 disp ready", bus_rdata, 16'h8000);
        chk("R9 disp_vld", disp_vld, 0);
        chk("R9 disp_char", disp_char, 0);
        rst_n = 1;
        @(negedge clk);

        // R3 key arrives, R5 overwrite, R4 read clears
        step(16'h0000, 0, 0, 0, 1, 8'h41, 0);
        step(16'hFE00, 1, 0, 0, 1, 8'h42, 0);            // R3 ready seen; R5 overwrite
        step(16'hFE02, 1, 0, 0, 0, 0, 0);                // R5 expects 0x42
        step(16'hFE00, 1, 0, 0, 0, 0, 0);                // R4 cleared
        chk("R4 ready cleared after read", bus_rdata, 16'h0000);
        // R4 strobe and read together: strobe wins
        step(16'hFE02, 1, 0, 0, 1, 8'h7E, 0);
        step(16'hFE00, 1, 0, 0, 0, 0, 0);
        chk("R4 strobe wins over read", bus_rdata, 16'h8000);
        // R10 writes to status/data that have no effect
        step(16'hFE00, 0, 1, 16'h0000, 0, 0, 0);
        step(16'hFE02, 0, 1, 16'h0011, 0, 0, 0);
        step(16'hFE04, 0, 1, 16'h0000, 0, 0, 0);
        step(16'hFE02, 1, 0, 0, 0, 0, 0);
        chk("R10 kbd data kept", bus_rdata, 16'h007E);
        // R6 send, R8 busy write dropped, R7 late ack
        step(16'hFE06, 0, 1, 16'hFF33, 0, 0, 1);         // ack while ready: ignored
        chk("R6 pulse", disp_vld, 1);
        step(16'hFE06, 0, 1, 16'h0044, 0, 0, 0);         // R8 dropped
        step(16'hFE04, 1, 0, 0, 0, 0, 0);
        chk("R8 char kept", disp_char, 8'h33);
        step(16'hFE04, 1, 0, 0, 0, 0, 1);                // R7 late ack
        step(16'hFE04, 1, 0, 0, 0, 0, 0);
        chk("R7 ready after ack", bus_rdata, 16'h8000);
        // R7 ack during the valid cycle
        step(16'hFE06, 0, 1, 16'h0055, 0, 0, 0);
        step(16'hFE04, 1, 0, 0, 0, 0, 1);
        step(16'hFE04, 1, 0, 0, 0, 0, 0);
        chk("R7 early ack", bus_rdata, 16'h8000);
        // R1 neighbours go to memory
        step(16'hFE01, 1, 0, 0, 0, 0, 0);
        step(16'hFE08, 0, 1, 16'h1111, 0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            a = ($urandom_range(0, 9) < 8) ? addrs[$urandom_range(0, 7)] : 16'($urandom);
            step(a, $urandom_range(0, 1), $urandom_range(0, 2) == 0, 16'($urandom),
                 $urandom_range(0, 4) == 0, 8'($urandom), $urandom_range(0, 3) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule